// File: doc/BRIEF.md
# Component Video Timing Code Parser

This block takes an 8-bit multiplexed component video stream, one byte per clock when a clock enable is high. In the stream, luma, both colour-difference components and the line/field timing share the same byte lane. The block finds the four-byte timing codes embedded in that stream. From each code it recovers the field bit and the vertical blanking bit. It also marks the start and end of each active line.

Between a start code and an end code, the bytes arrive in the repeating order Cb, Y, Cr, Y. The block keeps only the luma bytes and drops the chroma. Each luma byte is presented with a valid strobe and a pixel index. The pixel index restarts at zero on every start code, so the 720-sample active region stays aligned to the code even when line lengths drift.

A downstream scaler or line store can use the luma strobe and index directly as its write enable and write address. It can use the field bit to pick the field buffer.

Top module: `vid_sync_parser`

## Requirements
- R1: While reset is held, every output is 0.
- R2: A timing code is the byte run FF, 00, 00, then a code byte whose bit 7 is 1, with all four bytes accepted under clock enable. If bit 4 of the code byte is 0, `savPulse` is high for exactly one clock, starting one clock after the code byte is accepted. If bit 4 is 1, `eavPulse` is high instead, with the same timing. Bits 3..0 of the code byte have no effect.
- R3: `fieldId` takes bit 6 and `vBlank` takes bit 5 of each complete code byte. Both change on the same clock as the pulse, and otherwise hold their values.
- R4: A run that breaks before completion produces no pulse and changes neither `fieldId` nor `vBlank`. Examples are FF, 00 followed by a data byte, or FF, 00, 00 followed by a byte with bit 7 equal to 0.
- R5: After a start code, the accepted bytes count as Cb, Y, Cr, Y, repeating. Only the 2nd, 4th, 6th and so on raise `lumaValid`, for one clock, starting one clock after the byte is accepted. At the same time `lumaOut` carries that byte.
- R6: `pixIdx` is 0 for the first luma sample after a start code and increases by one per luma sample. A new start code in mid-line restarts the count at 0.
- R7: At most 720 luma samples are flagged between two start codes. Bytes beyond that are ignored until the next start code.
- R8: `lumaValid` stays low when the latest code set `vBlank`, and after an end code until the next start code.
- R9: A byte equal to 00 or FF is never flagged as luma.
- R10: A byte presented while `ce` is low is ignored. No pulse or luma strobe follows it, and the code matcher, field, blanking and pixel state hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Byte accept enable |
| dataIn | input | 8 | Multiplexed component byte |
| lumaOut | output | 8 | Last luma sample |
| lumaValid | output | 1 | One-clock strobe for `lumaOut` |
| pixIdx | output | 10 | Active pixel index of `lumaOut`, 0..719 |
| fieldId | output | 1 | Field bit from the latest code |
| vBlank | output | 1 | Vertical blanking bit from the latest code |
| savPulse | output | 1 | Start-of-active-line pulse |
| eavPulse | output | 1 | End-of-active-line pulse |

## Verification
Full lines of 1440 random non-reserved bytes, run with and without enable gaps, show whether luma is taken from the odd byte slots and indexed from zero. Lines that are too long, too short, or cut by a second start code separate the 720-sample cap from the re-centring of the index. Codes that break at each position, and code bytes with bit 7 cleared, show whether the matcher resets, while lines carrying the blanking bit show that luma is suppressed. Reserved bytes injected into active lines, and a complete code sent with the enable low, show that 00/FF is filtered and that gated bytes are ignored.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

  typedef enum logic [1:0] {
    M_IDLE,
    M_ONE,
    M_TWO,
    M_THREE
  } matchState_t;

  typedef struct packed {
    logic savHit;
    logic eavHit;
    logic lumaTake;
  } vspStrobe_t;

endpackage

// File: rtl/vsp_ctrl.sv
module vsp_ctrl
  import vsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lineFull,
  output vspStrobe_t        strobe,
  output logic              fieldId,
  output logic              vBlank
);

  localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ALL_ZEROS = '0;
  localparam int MARK_BIT = DATA_W - 1;
  localparam int F_BIT    = DATA_W - 2;
  localparam int V_BIT    = DATA_W - 3;
  localparam int H_BIT    = DATA_W - 4;

  matchState_t matchState, matchNext;
  logic active;
  logic lumaSlot;
  logic isMark, isOnes, isZeros, isReserved;

  always_comb begin
    isOnes     = (dataIn == ALL_ONES);
    isZeros    = (dataIn == ALL_ZEROS);
    isReserved = isOnes | isZeros;
    isMark     = (matchState == M_THREE) && dataIn[MARK_BIT];

    unique case (matchState)
      M_IDLE:  matchNext = isOnes ? M_ONE : M_IDLE;
      M_ONE:   matchNext = isZeros ? M_TWO : (isOnes ? M_ONE : M_IDLE);
      M_TWO:   matchNext = isZeros ? M_THREE : (isOnes ? M_ONE : M_IDLE);
      default: matchNext = isOnes ? M_ONE : M_IDLE;
    endcase

    strobe.savHit   = ce & isMark & ~dataIn[H_BIT];
    strobe.eavHit   = ce & isMark & dataIn[H_BIT];
    strobe.lumaTake = ce & active & lumaSlot & ~vBlank & ~isReserved
                      & ~isMark & ~lineFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchState <= M_IDLE;
      active     <= 1'b0;
      lumaSlot   <= 1'b0;
      fieldId    <= 1'b0;
      vBlank     <= 1'b0;
    end else if (ce) begin
      matchState <= matchNext;
      if (isMark) begin
        fieldId <= dataIn[F_BIT];
        vBlank  <= dataIn[V_BIT];
      end
      if (strobe.savHit) begin
        active   <= 1'b1;
        lumaSlot <= 1'b0;
      end else if (strobe.eavHit || (active && lineFull)) begin
        active <= 1'b0;
      end else if (active) begin
        lumaSlot <= ~lumaSlot;
      end
    end
  end

endmodule

// File: rtl/vsp_datapath.sv
module vsp_datapath
  import vsp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACTIVE_PIX = 720
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DATA_W-1:0]             dataIn,
  input  vspStrobe_t                    strobe,
  output logic [DATA_W-1:0]             lumaOut,
  output logic                          lumaValid,
  output logic [$clog2(ACTIVE_PIX)-1:0] pixIdx,
  output logic                          savPulse,
  output logic                          eavPulse,
  output logic                          lineFull
);

  localparam int IDX_W = $clog2(ACTIVE_PIX);
  localparam int CNT_W = $clog2(ACTIVE_PIX + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(ACTIVE_PIX);

  logic [CNT_W-1:0] pixCount;

  assign lineFull = (pixCount == CNT_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCount  <= '0;
      lumaOut   <= '0;
      lumaValid <= 1'b0;
      pixIdx    <= '0;
      savPulse  <= 1'b0;
      eavPulse  <= 1'b0;
    end else begin
      savPulse  <= strobe.savHit;
      eavPulse  <= strobe.eavHit;
      lumaValid <= strobe.lumaTake;
      if (strobe.lumaTake) begin
        lumaOut <= dataIn;
        pixIdx  <= IDX_W'(pixCount);
      end
      if (strobe.savHit) begin
        pixCount <= '0;
      end else if (strobe.lumaTake) begin
        pixCount <= pixCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vid_sync_parser.sv
module vid_sync_parser
  import vsp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACTIVE_PIX = 720
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ce,
  input  logic [DATA_W-1:0]             dataIn,
  output logic [DATA_W-1:0]             lumaOut,
  output logic                          lumaValid,
  output logic [$clog2(ACTIVE_PIX)-1:0] pixIdx,
  output logic                          fieldId,
  output logic                          vBlank,
  output logic                          savPulse,
  output logic                          eavPulse
);

  vspStrobe_t strobe;
  logic       lineFull;

  vsp_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .ce       (ce),
    .dataIn   (dataIn),
    .lineFull (lineFull),
    .strobe   (strobe),
    .fieldId  (fieldId),
    .vBlank   (vBlank)
  );

  vsp_datapath #(.DATA_W(DATA_W), .ACTIVE_PIX(ACTIVE_PIX)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .strobe    (strobe),
    .lumaOut   (lumaOut),
    .lumaValid (lumaValid),
    .pixIdx    (pixIdx),
    .savPulse  (savPulse),
    .eavPulse  (eavPulse),
    .lineFull  (lineFull)
  );

endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
  parameter int DATA_W     = 8,
  parameter int ACTIVE_PIX = 720
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          ce,
  input logic [DATA_W-1:0]             lumaOut,
  input logic                          lumaValid,
  input logic [$clog2(ACTIVE_PIX)-1:0] pixIdx,
  input logic                          fieldId,
  input logic                          vBlank,
  input logic                          savPulse,
  input logic                          eavPulse
);

  localparam int IDX_W = $clog2(ACTIVE_PIX);

  logic             seenLuma;
  logic [IDX_W-1:0] lastIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenLuma <= 1'b0;
      lastIdx  <= '0;
    end else if (savPulse) begin
      seenLuma <= 1'b0;
    end else if (lumaValid) begin
      seenLuma <= 1'b1;
      lastIdx  <= pixIdx;
    end
  end

  assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(savPulse && eavPulse));

  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!savPulse && !eavPulse) |-> ($stable(fieldId) && $stable(vBlank)));

  assert_first_index_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lumaValid && !seenLuma) |-> (pixIdx == '0));

  assert_index_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lumaValid && seenLuma) |-> (pixIdx == IDX_W'(lastIdx + 1'b1)));

  assert_index_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    lumaValid |-> (int'(pixIdx) < ACTIVE_PIX));

  assert_no_luma_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    lumaValid |-> !vBlank);

  assert_no_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    lumaValid |-> (lumaOut != '0 && lumaOut != {DATA_W{1'b1}}));

  assert_ce_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ce |=> (!lumaValid && !savPulse && !eavPulse));

endmodule

bind vid_sync_parser vsp_checker #(.DATA_W(DATA_W), .ACTIVE_PIX(ACTIVE_PIX)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .ce        (ce),
  .lumaOut   (lumaOut),
  .lumaValid (lumaValid),
  .pixIdx    (pixIdx),
  .fieldId   (fieldId),
  .vBlank    (vBlank),
  .savPulse  (savPulse),
  .eavPulse  (eavPulse)
);

// File: tb/vid_sync_parser_tb.sv
module vid_sync_parser_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       ce;
  logic [7:0] dataIn;
  logic [7:0] lumaOut;
  logic       lumaValid;
  logic [9:0] pixIdx;
  logic       fieldId, vBlank, savPulse, eavPulse;

  always #5 clk = ~clk;

  vid_sync_parser dut_i (
    .clk(clk), .rstN(rstN), .ce(ce), .dataIn(dataIn),
    .lumaOut(lumaOut), .lumaValid(lumaValid), .pixIdx(pixIdx),
    .fieldId(fieldId), .vBlank(vBlank),
    .savPulse(savPulse), .eavPulse(eavPulse)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] h0 = 8'h11, h1 = 8'h11, h2 = 8'h11;
  bit mActive = 0, mSlot = 0, mF = 0, mV = 0;
  int mCount = 0;
  int lumaSeen = 0, savSeen = 0, eavSeen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit en);
    bit exSav = 0, exEav = 0, exVal = 0;
    logic [7:0] exL = 8'h0;
    int exI = 0;
    dataIn = b;
    ce = en;
    if (en) begin
      if (h0 == 8'hFF && h1 == 8'h00 && h2 == 8'h00 && b[7]) begin
        mF = b[6];
        mV = b[5];
        if (!b[4]) begin
          exSav = 1; mActive = 1; mSlot = 0; mCount = 0;
        end else begin
          exEav = 1; mActive = 0;
        end
      end else if (mActive) begin
        if (mSlot && !mV && b != 8'h00 && b != 8'hFF && mCount < 720) begin
          exVal = 1; exL = b; exI = mCount; mCount++;
        end
        mSlot = !mSlot;
      end
      h0 = h1; h1 = h2; h2 = b;
    end
    @(posedge clk);
    @(negedge clk);
    check(savPulse == exSav, "R2", "savPulse", int'(savPulse), int'(exSav));
    check(eavPulse == exEav, "R2", "eavPulse", int'(eavPulse), int'(exEav));
    check(fieldId == mF, "R3", "fieldId", int'(fieldId), int'(mF));
    check(vBlank == mV, "R3", "vBlank", int'(vBlank), int'(mV));
    check(lumaValid == exVal, en ? "R5" : "R10", "lumaValid",
          int'(lumaValid), int'(exVal));
    check(!(lumaValid && (lumaOut == 8'h00 || lumaOut == 8'hFF)), "R9",
          "reservedLuma", int'(lumaOut), 1);
    if (exVal && lumaValid) begin
      check(lumaOut == exL, "R5", "lumaOut", int'(lumaOut), int'(exL));
      check(int'(pixIdx) == exI, "R6", "pixIdx", int'(pixIdx), exI);
    end
    if (lumaValid) lumaSeen++;
    if (savPulse) savSeen++;
    if (eavPulse) eavSeen++;
  endtask

  function automatic logic [7:0] dataByte();
    return 8'(($urandom % 254) + 1);
  endfunction

  task automatic sendCode(input bit f, input bit v, input bit h);
    sendByte(8'hFF, 1);
    sendByte(8'h00, 1);
    sendByte(8'h00, 1);
    sendByte({1'b1, f, v, h, 4'($urandom)}, 1);
  endtask

  task automatic sendData(input int n, input bit inject, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = dataByte();
      if (inject && ($urandom % 12 == 0)) b = ($urandom % 2) ? 8'hFF : 8'h00;
      if (gaps && ($urandom % 8 == 0)) sendByte(dataByte(), 0);
      sendByte(b, 1);
    end
  endtask

  task automatic sendLine(input bit f, input bit v, input int n,
                          input bit inject, input bit gaps);
    lumaSeen = 0;
    sendCode(f, v, 1'b0);
    sendData(n, inject, gaps);
    sendCode(f, v, 1'b1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit fSave;
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    ce = 1'b0;
    dataIn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!lumaValid && lumaOut == 0 && pixIdx == 0, "R1", "lumaOut/pixIdx/valid",
          int'(lumaValid) + int'(lumaOut) + int'(pixIdx), 0);
    check(!fieldId && !vBlank && !savPulse && !eavPulse, "R1", "flags/pulses",
          int'(fieldId) + int'(vBlank) + int'(savPulse) + int'(eavPulse), 0);
    rstN = 1'b1;

    // full lines, R5 and R7
    for (int l = 0; l < 4; l++) begin
      sendLine(l[0], 1'b0, 1440, 1'b0, l[1]);
      check(lumaSeen == 720, "R7", "lumaPerLine", lumaSeen, 720);
    end

    // too-long line capped at 720, R7
    sendLine(1'b1, 1'b0, 1600, 1'b0, 1'b0);
    check(lumaSeen == 720, "R7", "longLine", lumaSeen, 720);

    // short line, R6
    sendLine(1'b0, 1'b0, 200, 1'b0, 1'b1);
    check(lumaSeen == 100, "R6", "shortLine", lumaSeen, 100);

    // mid-line start code re-centres the index, R6
    lumaSeen = 0;
    sendCode(1'b0, 1'b0, 1'b0);
    sendData(300, 1'b0, 1'b0);
    sendCode(1'b0, 1'b0, 1'b0);
    sendData(1440, 1'b0, 1'b0);
    sendCode(1'b0, 1'b0, 1'b1);
    check(lumaSeen == 870, "R6", "recentredLine", lumaSeen, 870);

    // blanking line, R8
    sendLine(1'b1, 1'b1, 1440, 1'b0, 1'b0);
    check(lumaSeen == 0, "R8", "blankLine", lumaSeen, 0);

    // after end code no luma, R8
    sendLine(1'b1, 1'b0, 1440, 1'b0, 1'b0);
    lumaSeen = 0;
    sendData(100, 1'b0, 1'b0);
    check(lumaSeen == 0, "R8", "afterEnd", lumaSeen, 0);

    // reserved bytes injected, R9
    sendLine(1'b0, 1'b0, 1440, 1'b1, 1'b1);
    check(lumaSeen < 720, "R9", "injectedLine", lumaSeen, 719);

    // broken codes, R4
    fSave = fieldId;
    savSeen = 0; eavSeen = 0;
    sendByte(8'hFF, 1); sendByte(8'h00, 1); sendByte(8'h55, 1); sendByte(8'hC0, 1);
    sendByte(8'hFF, 1); sendByte(8'h00, 1); sendByte(8'h00, 1); sendByte(8'h60, 1);
    sendByte(8'hFF, 1); sendByte(8'h42, 1); sendByte(8'h00, 1); sendByte(8'hC0, 1);
    check(savSeen == 0 && eavSeen == 0, "R4", "pulsesOnBroken", savSeen + eavSeen, 0);
    check(fieldId == fSave && !vBlank, "R4", "fieldOnBroken", int'(fieldId), int'(fSave));

    // code byte sent with ce low is ignored, R10
    sendByte(8'hFF, 1); sendByte(8'h00, 1); sendByte(8'h00, 1);
    sendByte(8'hE0, 0); sendByte(8'hF0, 0);
    check(savSeen == 0 && eavSeen == 0, "R10", "pulsesWithCeLow", savSeen + eavSeen, 0);
    check(fieldId == fSave && !vBlank, "R10", "fieldWithCeLow",
          int'(fieldId), int'(fSave));
    // matcher state held across gap: completing code now counts
    sendByte(8'hC0, 1);
    check(savSeen == 1 && fieldId == 1'b1, "R10", "matcherHeld", savSeen, 1);

    // random mixed stream
    for (int i = 0; i < 3000; i++) sendByte(8'($urandom), ($urandom % 6) != 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule